// File: doc/BRIEF.md
# CAN Controller Operating-Mode Sequencer

This block decides which operating mode a CAN protocol engine is in and filters software writes to the mode control register. Software writes one 8-bit control word that holds a reset request, a halt request, a sleep request, an auto-wake enable, a halt-on-bus-off enable and a 3-bit test-mode code. The block reports the present mode, a one-hot decode of the test mode, a receive-enable for the protocol engine, and a one-cycle pulse that makes the error logic return to error-active at once. The bit-level protocol, the error counters and the message storage sit outside this block.

Five states make up the state machine, with mode codes RESET=0, HALT=1, SLEEP=2, OPER=3 and BUSOFF=4.
- Reset request set (any state) goes to RESET.
- RESET with reset cleared goes to HALT if halt is requested, and to OPER if it is not.
- OPER on bus-off goes to BUSOFF. OPER with a halt request goes to HALT at bus idle.
- HALT with a sleep request goes to SLEEP. HALT with the halt request cleared goes to OPER.
- SLEEP with sleep cleared goes to HALT or OPER, depending on the halt request.
- BUSOFF with recovery complete goes to HALT or OPER. BUSOFF with halt requested and halt-on-bus-off enabled goes to HALT at once and sends the force pulse.

In sleep, a dominant bit on the receive input can clear the sleep request by itself when auto-wake is enabled. The receive input passes through a two-stage synchronizer first. The frame that caused the wake is not received.

Top module: `canmode_seq`

## Requirements
- R1: After reset, mode is RESET (0), the control readback is 0x01, the test-mode decode is 6'b000001, and force_ea and rx_enable are low.
- R2: The control word has these fields: bit0 reset request, bit1 halt request, bit2 sleep request, bit3 auto-wake enable, bit4 halt-on-bus-off enable, bits 7:5 test-mode code. Each code from 0 to 5 sets tm_onehot bit number equal to the code. The codes are 0 normal, 1 listen-only, 2 external self-test, 3 internal self-test, 4 write error counter, 5 error passive.
- R3: A write that carries test-mode code 6 or 7 keeps the stored code. All other fields of that write still take effect.
- R4: Bits 3 and 4 accept writes only while the mode is RESET or HALT. In every other mode, writes to them are ignored.
- R5: After the write that clears bit0 in RESET, the readback changes on the next clock edge and the mode changes one edge later: to OPER, or to HALT if bit1 is set.
- R6: In OPER with bit1 set, the mode becomes HALT only on a clock edge at which bus_idle is high. Clearing bit1 in HALT returns the mode to OPER.
- R7: In HALT, setting bit2 enters SLEEP. A software write that clears bit2 leaves SLEEP, to HALT if bit1 is set and to OPER otherwise.
- R8: In SLEEP with bit3 set, a low rx_in clears bit2 three edges after it is first sampled, and the mode leaves SLEEP on the fourth edge.
- R9: In SLEEP with bit3 clear, a low rx_in has no effect on bit2 or on the mode.
- R10: rx_enable is high only in OPER. After an auto-wake it stays low until a bus_idle indication.
- R11: In BUSOFF with bit4 clear, a halt request is deferred. The mode stays BUSOFF until recov_done, then becomes HALT with no force pulse.
- R12: In BUSOFF with bit4 set, a halt request enters HALT on the next edge. force_ea is high for exactly the cycle in which the mode first reads HALT.
- R13: In OPER, bus_off high moves the mode to BUSOFF. recov_done with no halt request returns the mode to OPER.
- R14: When bit0 is set, the mode becomes RESET on the next edge, whatever the mode was.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Control-word write strobe |
| wr_data | input | 8 | Control word to write |
| rx_in | input | 1 | Raw receive bit, 0 = dominant |
| bus_idle | input | 1 | Protocol engine reports bus idle |
| bus_off | input | 1 | Protocol engine reports bus-off |
| recov_done | input | 1 | Bus-off recovery complete pulse |
| mode | output | 3 | Current mode code |
| ctrl_rd | output | 8 | Stored control word |
| tm_onehot | output | 6 | One-hot test-mode decode |
| force_ea | output | 1 | Pulse that forces error-active |
| rx_enable | output | 1 | Receive allowed |

## Verification
A wrong state register shows up on `mode` at the very next edge, because that port is the state register itself. Wrong write filtering shows up in `ctrl_rd` one edge after the write. A stuck wake path shows up as `mode` still reading SLEEP four edges after a dominant bit. A wrong bus-off decision shows up as `mode` leaving BUSOFF too early or too late, or as `force_ea` pulsing in the wrong cycle or not at all.

// File: rtl/canmode_pkg.sv
package canmode_pkg;

    localparam int CTRL_W     = 8;
    localparam int TM_W       = 3;
    localparam int TM_NUM     = 6;
    localparam int TM_MAX     = TM_NUM - 1;

    localparam int B_RST      = 0;
    localparam int B_HALT     = 1;
    localparam int B_SLEEP    = 2;
    localparam int B_AWAKE    = 3;
    localparam int B_HBO      = 4;
    localparam int B_TM_LO    = 5;
    localparam int B_TM_HI    = B_TM_LO + TM_W - 1;

    typedef enum logic [2:0] {
        MD_RESET  = 3'd0,
        MD_HALT   = 3'd1,
        MD_SLEEP  = 3'd2,
        MD_OPER   = 3'd3,
        MD_BUSOFF = 3'd4
    } mode_e;

endpackage

// File: rtl/canmode_ctrl_reg.sv
module canmode_ctrl_reg
    import canmode_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CTRL_W-1:0] wr_data,
    input  mode_e             mode_i,
    input  logic              wake_i,
    output logic              rst_req,
    output logic              halt_req,
    output logic              sleep_req,
    output logic              awake_en,
    output logic              hbo_en,
    output logic [TM_W-1:0]   tmode,
    output logic [CTRL_W-1:0] ctrl_rd
);

    logic            lock_open;
    logic            tm_ok;
    logic [TM_W-1:0] tm_new;

    assign lock_open = (mode_i == MD_RESET) || (mode_i == MD_HALT);
    assign tm_new    = wr_data[B_TM_HI:B_TM_LO];
    assign tm_ok     = (int'(tm_new) <= TM_MAX);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rst_req   <= 1'b1;
            halt_req  <= 1'b0;
            sleep_req <= 1'b0;
            awake_en  <= 1'b0;
            hbo_en    <= 1'b0;
            tmode     <= '0;
        end else begin
            if (wr_en) begin
                rst_req  <= wr_data[B_RST];
                halt_req <= wr_data[B_HALT];
                if (lock_open) begin
                    awake_en <= wr_data[B_AWAKE];
                    hbo_en   <= wr_data[B_HBO];
                end
                if (tm_ok) begin
                    tmode <= tm_new;
                end
            end
            if (wake_i) begin
                sleep_req <= 1'b0;
            end else if (wr_en) begin
                sleep_req <= wr_data[B_SLEEP];
            end
        end
    end

    always_comb begin
        ctrl_rd                  = '0;
        ctrl_rd[B_RST]           = rst_req;
        ctrl_rd[B_HALT]          = halt_req;
        ctrl_rd[B_SLEEP]         = sleep_req;
        ctrl_rd[B_AWAKE]         = awake_en;
        ctrl_rd[B_HBO]           = hbo_en;
        ctrl_rd[B_TM_HI:B_TM_LO] = tmode;
    end

    AST_TM_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        int'(tmode) <= TM_MAX); // R3

    AST_LOCKED_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i != MD_RESET && mode_i != MD_HALT) |=> $stable({awake_en, hbo_en})); // R4

    AST_NO_BUS_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
        (sleep_req && !awake_en && !wr_en) |=> sleep_req); // R9

endmodule

// File: rtl/canmode_wake_det.sv
module canmode_wake_det #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_in,
    input  logic arm,
    output logic wake
);

    localparam int LAST = SYNC_STAGES - 1;

    logic [SYNC_STAGES-1:0] sync_q;

    generate
        for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) sync_q[g] <= 1'b1;
                    else        sync_q[g] <= rx_in;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) sync_q[g] <= 1'b1;
                    else        sync_q[g] <= sync_q[g-1];
                end
            end
        end
    endgenerate

    assign wake = arm && !sync_q[LAST];

endmodule

// File: rtl/canmode_fsm.sv
module canmode_fsm
    import canmode_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  rst_req,
    input  logic  halt_req,
    input  logic  sleep_req,
    input  logic  hbo_en,
    input  logic  bus_idle,
    input  logic  bus_off,
    input  logic  recov_done,
    input  logic  wake,
    output mode_e state,
    output logic  force_ea,
    output logic  rx_enable
);

    mode_e state_nx;
    logic  take_fast_halt;
    logic  suppress_q;

    assign take_fast_halt = (state == MD_BUSOFF) && !rst_req && halt_req && hbo_en;

    always_comb begin
        state_nx = state;
        if (rst_req) begin
            state_nx = MD_RESET;
        end else begin
            unique case (state)
                MD_RESET:  state_nx = halt_req ? MD_HALT : MD_OPER;
                MD_OPER: begin
                    if (bus_off)                   state_nx = MD_BUSOFF;
                    else if (halt_req && bus_idle) state_nx = MD_HALT;
                end
                MD_HALT: begin
                    if (sleep_req)      state_nx = MD_SLEEP;
                    else if (!halt_req) state_nx = MD_OPER;
                end
                MD_SLEEP: begin
                    if (!sleep_req) state_nx = halt_req ? MD_HALT : MD_OPER;
                end
                MD_BUSOFF: begin
                    if (halt_req && hbo_en) state_nx = MD_HALT;
                    else if (recov_done)    state_nx = halt_req ? MD_HALT : MD_OPER;
                end
                default:   state_nx = MD_RESET;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= MD_RESET;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            force_ea   <= 1'b0;
            suppress_q <= 1'b0;
        end else begin
            force_ea <= take_fast_halt;
            if (wake && state == MD_SLEEP) suppress_q <= 1'b1;
            else if (bus_idle)             suppress_q <= 1'b0;
        end
    end

    assign rx_enable = (state == MD_OPER) && !suppress_q;

    AST_FORCE_FROM_BUSOFF: assert property (@(posedge clk) disable iff (!rst_n)
        force_ea |-> (state == MD_HALT && $past(state) == MD_BUSOFF)); // R12

    AST_HALT_DEFERRED: assert property (@(posedge clk) disable iff (!rst_n)
        (state == MD_BUSOFF && !hbo_en && !recov_done && !rst_req) |=> state == MD_BUSOFF); // R11

    AST_FORCE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        force_ea |=> !force_ea); // R12

endmodule

// File: rtl/canmode_seq.sv
module canmode_seq
    import canmode_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CTRL_W-1:0] wr_data,
    input  logic              rx_in,
    input  logic              bus_idle,
    input  logic              bus_off,
    input  logic              recov_done,
    output logic [2:0]        mode,
    output logic [CTRL_W-1:0] ctrl_rd,
    output logic [TM_NUM-1:0] tm_onehot,
    output logic              force_ea,
    output logic              rx_enable
);

    mode_e           state;
    logic            rst_req, halt_req, sleep_req, awake_en, hbo_en;
    logic [TM_W-1:0] tmode;
    logic            wake;

    canmode_ctrl_reg u_reg (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .mode_i    (state),
        .wake_i    (wake),
        .rst_req   (rst_req),
        .halt_req  (halt_req),
        .sleep_req (sleep_req),
        .awake_en  (awake_en),
        .hbo_en    (hbo_en),
        .tmode     (tmode),
        .ctrl_rd   (ctrl_rd)
    );

    canmode_wake_det #(.SYNC_STAGES(2)) u_wake (
        .clk   (clk),
        .rst_n (rst_n),
        .rx_in (rx_in),
        .arm   ((state == MD_SLEEP) && awake_en),
        .wake  (wake)
    );

    canmode_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .rst_req    (rst_req),
        .halt_req   (halt_req),
        .sleep_req  (sleep_req),
        .hbo_en     (hbo_en),
        .bus_idle   (bus_idle),
        .bus_off    (bus_off),
        .recov_done (recov_done),
        .wake       (wake),
        .state      (state),
        .force_ea   (force_ea),
        .rx_enable  (rx_enable)
    );

    generate
        for (genvar i = 0; i < TM_NUM; i++) begin : g_tm_dec
            assign tm_onehot[i] = (tmode == TM_W'(i));
        end
    endgenerate

    assign mode = state;

    AST_TM_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(tm_onehot) == 1); // R2

    AST_RXEN_ONLY_OPER: assert property (@(posedge clk) disable iff (!rst_n)
        rx_enable |-> mode == 3'(MD_OPER)); // R10

    AST_RESET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_rd[B_RST] |=> mode == 3'(MD_RESET)); // R14

endmodule

// File: tb/canmode_seq_tb.sv
module canmode_seq_tb;

    localparam int CLK_PERIOD = 10;

    localparam int K_MODE = 0;
    localparam int K_CTRL = 1;
    localparam int K_TM   = 2;
    localparam int K_FEA  = 3;
    localparam int K_RXEN = 4;

    localparam int M_RESET = 0, M_HALT = 1, M_SLEEP = 2, M_OPER = 3, M_BUSOFF = 4;

    typedef struct {
        int    kind;
        int    val;
        string tag;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic       rx_in = 1'b1;
    logic       bus_idle = 1'b0;
    logic       bus_off = 1'b0;
    logic       recov_done = 1'b0;
    logic [2:0] mode;
    logic [7:0] ctrl_rd;
    logic [5:0] tm_onehot;
    logic       force_ea;
    logic       rx_enable;

    int   n_total = 0;
    int   n_bad   = 0;
    bit   done    = 1'b0;
    exp_t sb_q[$];

    canmode_seq u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .rx_in      (rx_in),
        .bus_idle   (bus_idle),
        .bus_off    (bus_off),
        .recov_done (recov_done),
        .mode       (mode),
        .ctrl_rd    (ctrl_rd),
        .tm_onehot  (tm_onehot),
        .force_ea   (force_ea),
        .rx_enable  (rx_enable)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic int actual(int kind);
        case (kind)
            K_MODE:  return int'(mode);
            K_CTRL:  return int'(ctrl_rd);
            K_TM:    return int'(tm_onehot);
            K_FEA:   return int'(force_ea);
            default: return int'(rx_enable);
        endcase
    endfunction

    // monitor: compares queued expectations shortly after each falling edge
    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (sb_q.size() > 0) begin
                exp_t it;
                int   a;
                it = sb_q.pop_front();
                a  = actual(it.kind);
                n_total++;
                if (a !== it.val) begin
                    n_bad++;
                    $display("FAIL %s kind=%0d actual=0x%0h expected=0x%0h", it.tag, it.kind, a, it.val);
                end
            end
        end
    end

    task automatic expect_now(int kind, int val, string tag);
        exp_t it;
        it.kind = kind;
        it.val  = val;
        it.tag  = tag;
        sb_q.push_back(it);
    endtask

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(logic [7:0] d);
        wr_en   = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_total++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("test done: total=%0d bad=%0d", n_total, n_bad);
            $finish;
        end
    end

    initial begin
        cyc(3);
        rst_n = 1'b1;
        cyc(1);
        expect_now(K_MODE, M_RESET, "R1");
        expect_now(K_CTRL, 'h01, "R1");
        expect_now(K_TM, 'b000001, "R1");
        expect_now(K_FEA, 0, "R1");
        expect_now(K_RXEN, 0, "R1");

        wr(8'h19);
        expect_now(K_CTRL, 'h19, "R4 open in reset");

        for (int c = 0; c < 6; c++) begin
            wr(8'((c << 5) | 'h19));
            expect_now(K_TM, 1 << c, "R2");
        end
        wr(8'((6 << 5) | 'h19));
        expect_now(K_TM, 1 << 5, "R3 code6");
        expect_now(K_CTRL, 'hB9, "R3 code6");
        wr(8'((7 << 5) | 'h11));
        expect_now(K_TM, 1 << 5, "R3 code7");
        expect_now(K_CTRL, 'hB1, "R3 other fields");
        wr(8'h19);

        wr(8'h08);
        expect_now(K_CTRL, 'h08, "R5 readback");
        expect_now(K_MODE, M_RESET, "R5 not yet");
        cyc(1);
        expect_now(K_MODE, M_OPER, "R5");
        expect_now(K_RXEN, 1, "R10 oper");

        wr(8'h10);
        expect_now(K_CTRL, 'h08, "R4 locked");

        bus_off = 1'b1;
        cyc(1);
        bus_off = 1'b0;
        expect_now(K_MODE, M_BUSOFF, "R13");
        expect_now(K_RXEN, 0, "R10 busoff");

        wr(8'h0A);
        cyc(3);
        expect_now(K_MODE, M_BUSOFF, "R11 deferred");
        expect_now(K_FEA, 0, "R11");
        recov_done = 1'b1;
        cyc(1);
        recov_done = 1'b0;
        expect_now(K_MODE, M_HALT, "R11 after recovery");
        expect_now(K_FEA, 0, "R11 no force");

        wr(8'h1A);
        expect_now(K_CTRL, 'h1A, "R4 open in halt");
        wr(8'h18);
        cyc(1);
        expect_now(K_MODE, M_OPER, "R6 unhalt");

        wr(8'h1A);
        cyc(2);
        expect_now(K_MODE, M_OPER, "R6 waits idle");
        bus_idle = 1'b1;
        cyc(1);
        bus_idle = 1'b0;
        expect_now(K_MODE, M_HALT, "R6 idle halt");
        wr(8'h18);
        cyc(1);
        expect_now(K_MODE, M_OPER, "R6 unhalt");

        bus_off = 1'b1;
        cyc(1);
        bus_off = 1'b0;
        expect_now(K_MODE, M_BUSOFF, "R13");
        recov_done = 1'b1;
        cyc(1);
        recov_done = 1'b0;
        expect_now(K_MODE, M_OPER, "R13 recover");

        bus_off = 1'b1;
        cyc(1);
        bus_off = 1'b0;
        wr(8'h1A);
        expect_now(K_MODE, M_BUSOFF, "R12 pre");
        expect_now(K_FEA, 0, "R12 pre");
        cyc(1);
        expect_now(K_MODE, M_HALT, "R12 immediate");
        expect_now(K_FEA, 1, "R12 pulse");
        cyc(1);
        expect_now(K_FEA, 0, "R12 one cycle");
        expect_now(K_MODE, M_HALT, "R12 stays");

        wr(8'h1E);
        cyc(1);
        expect_now(K_MODE, M_SLEEP, "R7 enter");
        expect_now(K_RXEN, 0, "R10 sleep");

        rx_in = 1'b0;
        cyc(2);
        expect_now(K_CTRL, 'h1E, "R8 not yet");
        cyc(1);
        expect_now(K_CTRL, 'h1A, "R8 sleep cleared");
        expect_now(K_MODE, M_SLEEP, "R8 still");
        cyc(1);
        rx_in = 1'b1;
        expect_now(K_MODE, M_HALT, "R8 woke");

        wr(8'h18);
        cyc(1);
        expect_now(K_MODE, M_OPER, "R10 oper");
        expect_now(K_RXEN, 0, "R10 suppressed");
        bus_idle = 1'b1;
        cyc(1);
        bus_idle = 1'b0;
        expect_now(K_RXEN, 1, "R10 released");

        wr(8'h1A);
        bus_idle = 1'b1;
        cyc(1);
        bus_idle = 1'b0;
        expect_now(K_MODE, M_HALT, "R6");
        wr(8'h12);
        expect_now(K_CTRL, 'h12, "R4 clear awake");
        wr(8'h16);
        cyc(1);
        expect_now(K_MODE, M_SLEEP, "R7");
        rx_in = 1'b0;
        cyc(6);
        expect_now(K_MODE, M_SLEEP, "R9 no wake");
        expect_now(K_CTRL, 'h16, "R9 sleep kept");
        rx_in = 1'b1;
        wr(8'h12);
        cyc(1);
        expect_now(K_MODE, M_HALT, "R7 software exit");

        wr(8'h18);
        cyc(1);
        expect_now(K_MODE, M_OPER, "R6");
        wr(8'h19);
        cyc(1);
        expect_now(K_MODE, M_RESET, "R14");

        cyc(2);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", n_total, n_bad);
        $finish;
    end

endmodule